// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Flagged Queue

This block is the receive half of an asynchronous serial port. A baud-rate generator elsewhere provides a one-cycle sample tick at sixteen times the bit rate. The block synchronises the serial line and finds the start of each character. It checks that start at mid-bit and then collects 5 to 9 data bits, least significant first. An optional even or odd parity bit follows, and then one stop bit.

Every finished character goes into a two-entry queue. Each entry carries the character's own frame-error and parity-error flags, so software sees status and data from the same character together. The flag outputs always describe the oldest entry. Software reads them first and then pulses the pop input to consume the data, which moves the status to the next entry.

A receive-complete flag shows that the queue holds unread data. A level interrupt follows that flag when both the local and the global interrupt enables are set. When the queue is full and another character completes, the overrun flag goes high. From then on every arriving character is dropped until software pops an entry. Dropping the receiver enable empties the queue and clears all flags in the same cycle.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the receive-complete flag, the interrupt, the overrun flag, both error flags and the data output are all 0.
- R2: The length code `len_sel` gives the number of data bits as 5 + code: 0 gives 5 bits and 4 gives 9 bits. Codes above 4 also give 9 bits. Bits arrive least significant first and are right-justified in `rx_data`, with the unused upper bits at 0.
- R3: When `par_en`=1 a parity bit follows the data bits. With `par_odd`=0 the number of ones across the data bits and the parity bit must be even; with `par_odd`=1 it must be odd. If the count is wrong, `err_par` is 1 for that character. When `par_en`=0 no parity bit is expected and `err_par` is always 0.
- R4: `err_frame` is 1 when the first stop bit is sampled as 0, and 0 when it is sampled as 1.
- R5: The queue holds two characters, each stored with its own error flags. The data and flag outputs show the oldest entry, and a pop moves them to the next entry.
- R6: `rx_done` is 1 exactly while the receiver is enabled and at least one unread entry is queued.
- R7: `irq` is 1 only when `rx_done`, `irq_en` and `gie` are all 1.
- R8: When the queue is full and another character completes, `overrun` goes to 1. While it is 1, every new character is discarded. A pop clears it.
- R9: Clearing `rx_en` at once forces `rx_done`, `irq`, `overrun` and the outputs to 0, and empties the queue. After re-enabling, the queue is still empty.
- R10: A low level on the line that reads 1 again at the mid-bit start check is treated as a false start. It produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 flushes the queue |
| sample_tick | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial input line, idle high |
| len_sel | input | 3 | Data length code (bits = 5 + code, capped at 9) |
| par_en | input | 1 | Expect and check a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| irq_en | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rd_pop | input | 1 | One-cycle pulse that consumes the oldest entry |
| rx_data | output | 9 | Data of the oldest entry |
| err_frame | output | 1 | Frame-error flag of the oldest entry |
| err_par | output | 1 | Parity-error flag of the oldest entry |
| overrun | output | 1 | Characters have been lost since the last pop |
| rx_done | output | 1 | Unread data is queued |
| irq | output | 1 | Receive-complete interrupt |

## Verification
The hardest state to reach is overrun while the queue still holds two intact characters, each with different flags. The bench gets there by sending three or four complete serial frames back to back without popping. It then pops one entry at a time and checks that the first two characters come out in order with their own flags, and that the later frames were lost. A flush is tested on a full queue at the same negative clock edge where the enable drops. The main sweep covers every data length, every parity mode and injected stop-bit and parity faults.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int unsigned DW = 9;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          fe;
    logic          pe;
  } rx_entry_t;

  // 1 when data plus received parity bit fail the selected parity sense
  function automatic logic par_err(logic [DW-1:0] d, logic pbit, logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/srq_sampler.sv
module srq_sampler
  import srq_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      rxd,
  input  logic [2:0] len_sel,
  input  logic      par_en,
  input  logic      par_odd,
  output rx_entry_t ch,
  output logic      ch_valid
);
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned IW   = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t            st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [IW-1:0]  idx_q, idx_d, nbits;
  logic [DW-1:0]  dat_q, dat_d;
  logic           pb_q, pb_d;
  logic           s1_q, s2_q;
  logic           vld_d;
  rx_entry_t      ch_q, ch_d;

  assign nbits = (len_sel > 3'd4) ? IW'(DW) : IW'(5) + IW'(len_sel);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    dat_d = dat_q;
    pb_d  = pb_q;
    vld_d = 1'b0;
    ch_d  = ch_q;
    if (!en) begin
      st_d  = S_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      case (st_q)
        S_IDLE: if (!s2_q) begin
          st_d  = S_START;
          cnt_d = '0;
        end
        S_START: if (cnt_q == MID) begin
          cnt_d = '0;
          if (s2_q) st_d = S_IDLE;
          else begin
            st_d  = S_DATA;
            idx_d = '0;
            dat_d = '0;
          end
        end else cnt_d = cnt_q + 1'b1;
        S_DATA: if (cnt_q == LAST) begin
          cnt_d = '0;
          for (int i = 0; i < DW; i++)
            if (idx_q == IW'(i)) dat_d[i] = s2_q;
          if (idx_q == nbits - IW'(1)) st_d = par_en ? S_PAR : S_STOP;
          else idx_d = idx_q + 1'b1;
        end else cnt_d = cnt_q + 1'b1;
        S_PAR: if (cnt_q == LAST) begin
          cnt_d = '0;
          pb_d  = s2_q;
          st_d  = S_STOP;
        end else cnt_d = cnt_q + 1'b1;
        S_STOP: if (cnt_q == LAST) begin
          cnt_d   = '0;
          st_d    = S_IDLE;
          vld_d   = 1'b1;
          ch_d.data = dat_q;
          ch_d.fe   = ~s2_q;
          ch_d.pe   = par_en & par_err(dat_q, pb_q, par_odd);
        end else cnt_d = cnt_q + 1'b1;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b1;
      s2_q     <= 1'b1;
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      dat_q    <= '0;
      pb_q     <= 1'b0;
      ch_q     <= '0;
      ch_valid <= 1'b0;
    end else begin
      s1_q     <= rxd;
      s2_q     <= s1_q;
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      dat_q    <= dat_d;
      pb_q     <= pb_d;
      ch_valid <= vld_d;
      if (vld_d) ch_q <= ch_d;
    end
  end

  assign ch = ch_q;
endmodule

// File: rtl/srq_buf.sv
module srq_buf
  import srq_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       push,
  input  rx_entry_t                  din,
  input  logic                       pop,
  output rx_entry_t                  head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovr
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  rx_entry_t      mem_q [DEPTH];
  logic [PW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0]  lvl_q, lvl_d;
  logic           ovr_q, ovr_d;
  logic           do_pop, do_push, full;

  assign full    = (lvl_q == LW'(DEPTH));
  assign do_pop  = pop && (lvl_q != '0);
  assign do_push = push && !ovr_q && (!full || do_pop);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    ovr_d = ovr_q;
    if (!en) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
      ovr_d = 1'b0;
    end else begin
      if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      lvl_d = lvl_q + LW'(do_push) - LW'(do_pop);
      if (do_pop) ovr_d = 1'b0;
      else if (push && full) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
      ovr_q <= ovr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (!en) mem_q[g] <= '0;
      else if (do_push && wp_q == PW'(g)) mem_q[g] <= din;
    end
  end

  assign head  = mem_q[rp_q];
  assign level = lvl_q;
  assign ovr   = ovr_q;
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srq_pkg::*;
#(
  parameter int unsigned OSR   = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          sample_tick,
  input  logic          rxd,
  input  logic [2:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          irq_en,
  input  logic          gie,
  input  logic          rd_pop,
  output logic [DW-1:0] rx_data,
  output logic          err_frame,
  output logic          err_par,
  output logic          overrun,
  output logic          rx_done,
  output logic          irq
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic          rs1_q, rs2_q, srst_n;
  rx_entry_t     ch, head;
  logic          ch_valid, ovr_q;
  logic [LW-1:0] buf_level;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  srq_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(srst_n), .en(rx_en), .tick(sample_tick), .rxd(rxd),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .ch(ch), .ch_valid(ch_valid)
  );

  srq_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(srst_n), .en(rx_en), .push(ch_valid), .din(ch),
    .pop(rd_pop & rx_en), .head(head), .level(buf_level), .ovr(ovr_q)
  );

  assign rx_done   = rx_en && (buf_level != '0);
  assign rx_data   = rx_done ? head.data : '0;
  assign err_frame = rx_done & head.fe;
  assign err_par   = rx_done & head.pe;
  assign overrun   = rx_en & ovr_q;
  assign irq       = rx_done & irq_en & gie;
endmodule

// File: rtl/srq_chk.sv
module srq_chk #(
  parameter int unsigned LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rd_pop,
  input logic          rx_done,
  input logic          irq,
  input logic          ovr_q,
  input logic [LW-1:0] buf_level
);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= LW'(2));
  a_r6_done_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_en);
  a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_done);
  a_r8_set_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(buf_level) == LW'(2));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !rd_pop && rx_en) |=> ovr_q);
  a_r8_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && rd_pop && rx_en) |=> !ovr_q);
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (buf_level == '0 && !ovr_q));
endmodule

bind serial_rx_queue srq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(srst_n), .rx_en(rx_en), .rd_pop(rd_pop),
  .rx_done(rx_done), .irq(irq), .ovr_q(ovr_q), .buf_level(buf_level)
);

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;
  localparam int BITC = 32; // 16 ticks, one tick every 2 clocks

  logic clk, rst_n, rx_en, tick, rxd, par_en, par_odd, irq_en, gie, rd_pop;
  logic [2:0] len_sel;
  logic [8:0] rx_data;
  logic err_frame, err_par, overrun, rx_done, irq;
  int errors, checks;

  serial_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sample_tick(tick), .rxd(rxd),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
    .gie(gie), .rd_pop(rd_pop), .rx_data(rx_data), .err_frame(err_frame),
    .err_par(err_par), .overrun(overrun), .rx_done(rx_done), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else tick <= ~tick;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input int len, input bit pen,
                      input bit odd, input bit bad_stop, input bit bad_par);
    logic p;
    p = odd ^ bad_par;
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxd = d[i];
      p = p ^ d[i];
      repeat (BITC) @(negedge clk);
    end
    if (pen) begin
      rxd = p;
      repeat (BITC) @(negedge clk);
    end
    rxd = ~bad_stop;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8:0] d, m;
    errors = 0; checks = 0;
    rst_n = 0; rx_en = 1; rxd = 1; len_sel = 3'd3; par_en = 0; par_odd = 0;
    irq_en = 1; gie = 1; rd_pop = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 done", rx_done, 0);
    check("R1 irq", irq, 0);
    check("R1 overrun", overrun, 0);
    check("R1 flags", {err_frame, err_par}, 0);
    check("R1 data", rx_data, 0);

    // R2/R3/R4 sweep: lengths x parity modes x patterns with fault injection
    for (int len = 5; len <= 9; len++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int v = 0; v < 4; v++) begin
          bit bs, bp;
          len_sel = 3'(len - 5);
          par_en = (pm != 0);
          par_odd = (pm == 2);
          d = 9'((v * 173 + len * 37 + pm * 91) % 512);
          m = 9'((1 << len) - 1);
          bs = (v == 2);
          bp = (v == 1) && (pm != 0);
          send(d, len, par_en, par_odd, bs, bp);
          check("R6 done after frame", rx_done, 1);
          check("R2 data", rx_data, int'(d & m));
          check("R4 frame error", err_frame, bs);
          check("R3 parity error", err_par, bp);
          pop();
          check("R6 done after pop", rx_done, 0);
        end
      end
    end
    // length codes above 4 act as 9 bits (R2)
    len_sel = 3'd7; par_en = 0;
    send(9'h1A5, 9, 0, 0, 0, 0);
    check("R2 code 7 data", rx_data, 'h1A5);
    pop();

    // R5 per-entry flags, oldest first
    len_sel = 3'd3; par_en = 1; par_odd = 0;
    send(9'h3C, 8, 1, 0, 1, 0);
    send(9'h81, 8, 1, 0, 0, 1);
    check("R5 head data", rx_data, 'h3C);
    check("R5 head fe", err_frame, 1);
    check("R5 head pe", err_par, 0);
    check("R8 no overrun at two", overrun, 0);
    pop();
    check("R5 second data", rx_data, 'h81);
    check("R5 second fe", err_frame, 0);
    check("R5 second pe", err_par, 1);
    pop();
    check("R5 empty", rx_done, 0);

    // R7 interrupt gating
    par_en = 0;
    send(9'h55, 8, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      irq_en = k[0]; gie = k[1];
      @(negedge clk);
      check("R7 irq", irq, (k == 3) ? 1 : 0);
    end
    pop();
    check("R7 irq when empty", irq, 0);

    // R8 overrun: four frames without pops
    send(9'h11, 8, 0, 0, 0, 0);
    send(9'h22, 8, 0, 0, 0, 0);
    send(9'h33, 8, 0, 0, 0, 0);
    check("R8 overrun set", overrun, 1);
    send(9'h44, 8, 0, 0, 0, 0);
    check("R8 overrun held", overrun, 1);
    check("R8 head kept", rx_data, 'h11);
    pop();
    check("R8 overrun cleared", overrun, 0);
    check("R8 second kept", rx_data, 'h22);
    pop();
    check("R8 later frames lost", rx_done, 0);

    // R9 flush on a full queue
    send(9'h66, 8, 0, 0, 1, 0);
    send(9'h77, 8, 0, 0, 0, 0);
    send(9'h78, 8, 0, 0, 0, 0);
    rx_en = 0;
    #1;
    check("R9 done same cycle", rx_done, 0);
    check("R9 irq same cycle", irq, 0);
    check("R9 overrun same cycle", overrun, 0);
    @(negedge clk);
    rx_en = 1;
    @(negedge clk);
    check("R9 still empty", rx_done, 0);
    check("R9 data cleared", rx_data, 0);
    check("R9 overrun cleared", overrun, 0);
    send(9'h5A, 8, 0, 0, 0, 0);
    check("R9 receives after re-enable", rx_data, 'h5A);
    pop();

    // R10 false start: short low glitch
    rxd = 0;
    repeat (8) @(negedge clk);
    rxd = 1;
    repeat (BITC * 12) @(negedge clk);
    check("R10 no character", rx_done, 0);
    send(9'hC3, 8, 0, 0, 0, 0);
    check("R10 next frame ok", rx_data, 'hC3);
    pop();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule